// File: doc/BRIEF.md
# Dual-Clock FIFO with Occupancy Flags

This block carries 8-bit words from a producer clocked by one clock to a consumer clocked by a second clock. The two clocks have no fixed relation. It holds sixteen words. Each side keeps its own binary pointer with one extra wrap bit. A Gray-coded copy of each pointer crosses to the far side through a two-flop synchronizer. The far copy is converted back to binary there and subtracted from the local pointer, so each side knows its occupancy without ever comparing raw binary pointers across the boundary.

The write side reports full, almost-full and half-full. The read side reports empty and almost-empty. Every flag is a register in its own clock domain. Each flag is computed from the local pointer as it will be after the current edge and from the far pointer as last synchronized. Because the far pointer can lag, full means "possibly full" and empty means "possibly empty". A stale view can delay the release of a flag but never lets a write overrun or a read underrun. Once both sides have been idle for a few cycles of each clock, every flag matches the true fill level.

The read data output is registered. After an accepted read it presents the oldest word. On every other read-clock cycle, and during reset, it shows zero.

Top module: `dcf_fifo`

## Requirements
- R1: Words leave in the order they were written, with none lost or repeated. Storage is 16 words of 8 bits. Addresses are 4 bits and wrap from 15 back to 0. Each pointer has a fifth wrap bit.
- R2: While `rst_n` is low, both pointers are 0, `empty` and `almost_empty` are 1, `full`, `almost_full` and `half_full` are 0, and `rdata` is 0.
- R3: A write is accepted only on a `wclk` edge with `wr_en` high and `full` low. A read is accepted only on an `rclk` edge with `rd_en` high and `empty` low. A rejected request changes neither storage nor pointers.
- R4: Occupancy is the write pointer minus the read pointer, modulo 32, over the 5-bit pointers. For example, write address 5 with read address 10 (write pointer one lap ahead) gives 11 words.
- R5: On the write side, `full` is 1 at occupancy 16. `half_full` is 1 at occupancy of 8 or more. `almost_full` is 1 at occupancy of `AFULL_LEVEL` (default 14) or more. All three are registered on `wclk`.
- R6: On the read side, `empty` is 1 when the read Gray pointer equals the synchronized write Gray pointer, wrap bit included. `almost_empty` is 1 at occupancy of `AEMPTY_LEVEL` (default 2) or less. Both are registered on `rclk`.
- R7: Each pointer crosses to the other domain only as Gray code through two flops. Successive Gray values differ in at most one bit.
- R8: Flags are conservative. Whenever `full` is 0, fewer than 16 words are stored. Whenever `empty` is 0, at least one word is stored. After both sides idle, all flags equal the true level.
- R9: `rdata` takes the oldest word on the `rclk` edge that accepts a read. It is 0 after every `rclk` edge that accepts no read.
- R10: The occupancy seen by either side never exceeds 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_en | input | 1 | Write request |
| wdata | input | DATA_W | Word to store |
| full | output | 1 | Possibly full; writes are refused |
| almost_full | output | 1 | Occupancy at or above AFULL_LEVEL |
| half_full | output | 1 | Occupancy at or above half the depth |
| rd_en | input | 1 | Read request |
| rdata | output | DATA_W | Registered read word, zero when no read |
| empty | output | 1 | Possibly empty; reads are refused |
| almost_empty | output | 1 | Occupancy at or below AEMPTY_LEVEL |

## Verification
The properties assume one reset that holds both domains together and is released while neither clock is at an edge. They also assume each request input is steady around the rising edge of its own clock. The stimulus changes `wr_en`, `wdata` and `rd_en` only on the falling edge of the matching clock. It releases reset between edges of both clocks and runs the two clocks at unrelated rates and phases. Flag levels are compared exactly only after both sides have idled long enough for the synchronizers to catch up. During traffic only the conservative direction of R8 is checked.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef struct packed {
        logic full;
        logic afull;
        logic half;
    } dcf_wflags_t;

    typedef struct packed {
        logic empty;
        logic aempty;
    } dcf_rflags_t;

endpackage

// File: rtl/dcf_ptr.sv
module dcf_ptr #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [PW-1:0] bin,
    output logic [PW-1:0] bin_nx,
    output logic [PW-1:0] gray
);

    assign bin_nx = bin + {{(PW-1){1'b0}}, inc};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin  <= '0;
            gray <= '0;
        end else begin
            bin  <= bin_nx;
            gray <= bin_nx ^ (bin_nx >> 1);
        end
    end

endmodule

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/dcf_occ.sv
module dcf_occ #(
    parameter int PW           = 5,
    parameter bit LOCAL_WRITES = 1'b1
) (
    input  logic [PW-1:0] local_bin,
    input  logic [PW-1:0] far_gray,
    output logic [PW-1:0] occ
);

    logic [PW-1:0] far_bin;

    // Gray to binary: each bit is the parity of itself and all higher bits
    for (genvar i = 0; i < PW; i++) begin : g_g2b
        assign far_bin[i] = ^(far_gray >> i);
    end

    if (LOCAL_WRITES) begin : g_wside
        assign occ = local_bin - far_bin;
    end else begin : g_rside
        assign occ = far_bin - local_bin;
    end

endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rword
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rword = store[raddr];

endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
    import dcf_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 4,
    parameter int AFULL_LEVEL  = 14,
    parameter int AEMPTY_LEVEL = 2
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              full,
    output logic              almost_full,
    output logic              half_full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              empty,
    output logic              almost_empty
);

    localparam int            DEPTH   = 1 << ADDR_W;
    localparam int            PW      = ADDR_W + 1;
    localparam logic [PW-1:0] LV_FULL = PW'(DEPTH);
    localparam logic [PW-1:0] LV_HALF = PW'(DEPTH / 2);
    localparam logic [PW-1:0] LV_AF   = PW'(AFULL_LEVEL);
    localparam logic [PW-1:0] LV_AE   = PW'(AEMPTY_LEVEL);

    // ---------------- write domain ----------------
    dcf_wflags_t   wflags_q;
    logic          wr_go;
    logic [PW-1:0] wbin, wbin_nx, wgray, rgray_w, wocc_nx;

    assign wr_go = wr_en && !wflags_q.full;

    dcf_ptr #(.PW(PW)) u_wptr (
        .clk(wclk), .rst_n(rst_n), .inc(wr_go),
        .bin(wbin), .bin_nx(wbin_nx), .gray(wgray)
    );

    dcf_sync2 #(.W(PW)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_w)
    );

    dcf_occ #(.PW(PW), .LOCAL_WRITES(1'b1)) u_wocc (
        .local_bin(wbin_nx), .far_gray(rgray_w), .occ(wocc_nx)
    );

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wflags_q <= '0;
        end else begin
            wflags_q.full  <= (wocc_nx == LV_FULL);
            wflags_q.afull <= (wocc_nx >= LV_AF);
            wflags_q.half  <= (wocc_nx >= LV_HALF);
        end
    end

    assign full        = wflags_q.full;
    assign almost_full = wflags_q.afull;
    assign half_full   = wflags_q.half;

    a_r3_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
        full |=> $stable(wbin));

    a_r10_wocc_bound: assert property (@(posedge wclk) disable iff (!rst_n)
        wocc_nx <= LV_FULL);

    a_r5_flag_nesting: assert property (@(posedge wclk) disable iff (!rst_n)
        full |-> (half_full && almost_full));

    a_r7_wgray_step: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    // ---------------- storage ----------------
    logic [DATA_W-1:0] rword;
    logic [PW-1:0]     rbin, rbin_nx, rgray;

    dcf_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .wclk(wclk), .we(wr_go), .waddr(wbin[ADDR_W-1:0]), .wdata(wdata),
        .raddr(rbin[ADDR_W-1:0]), .rword(rword)
    );

    // ---------------- read domain ----------------
    dcf_rflags_t   rflags_q;
    logic          rd_go;
    logic [PW-1:0] rgray_nx, wgray_r, rocc_nx;

    assign rd_go    = rd_en && !rflags_q.empty;
    assign rgray_nx = rbin_nx ^ (rbin_nx >> 1);

    dcf_ptr #(.PW(PW)) u_rptr (
        .clk(rclk), .rst_n(rst_n), .inc(rd_go),
        .bin(rbin), .bin_nx(rbin_nx), .gray(rgray)
    );

    dcf_sync2 #(.W(PW)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_r)
    );

    dcf_occ #(.PW(PW), .LOCAL_WRITES(1'b0)) u_rocc (
        .local_bin(rbin_nx), .far_gray(wgray_r), .occ(rocc_nx)
    );

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rflags_q.empty  <= 1'b1;
            rflags_q.aempty <= 1'b1;
            rdata           <= '0;
        end else begin
            rflags_q.empty  <= (rgray_nx == wgray_r);
            rflags_q.aempty <= (rocc_nx <= LV_AE);
            rdata           <= rd_go ? rword : '0;
        end
    end

    assign empty        = rflags_q.empty;
    assign almost_empty = rflags_q.aempty;

    a_r3_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
        empty |=> $stable(rbin));

    a_r10_rocc_bound: assert property (@(posedge rclk) disable iff (!rst_n)
        rocc_nx <= LV_FULL);

    a_r6_empty_nesting: assert property (@(posedge rclk) disable iff (!rst_n)
        empty |-> almost_empty);

    a_r9_idle_zero: assert property (@(posedge rclk) disable iff (!rst_n)
        !rd_go |=> (rdata == '0));

    a_r7_rgray_step: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);

endmodule

// File: tb/tb_dcf_fifo.sv
module tb_dcf_fifo;

    localparam int DW    = 8;
    localparam int DEPTH = 16;
    localparam int AF    = 14;
    localparam int AE    = 2;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          full, almost_full, half_full, empty, almost_empty;

    int            checks = 0;
    int            fails  = 0;
    logic [DW-1:0] q[$];
    logic [DW-1:0] rd_exp = '0;
    bit            rd_pend = 1'b0;
    logic [DW-1:0] wseq = 8'h01;

    dcf_fifo #(.DATA_W(DW), .ADDR_W(4), .AFULL_LEVEL(AF), .AEMPTY_LEVEL(AE)) dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
        .wr_en(wr_en), .wdata(wdata),
        .full(full), .almost_full(almost_full), .half_full(half_full),
        .rd_en(rd_en), .rdata(rdata),
        .empty(empty), .almost_empty(almost_empty)
    );

    // 50 MHz read clock, 10 MHz write clock with an unrelated phase
    always #10 rclk = ~rclk;
    initial begin
        #7;
        forever #50 wclk = ~wclk;
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic wr_cycle(bit en);
        @(negedge wclk);
        if (!full) check("R8 full low means room", 32'(q.size() < DEPTH), 1);
        wr_en = en;
        wdata = wseq;
        if (en && !full) begin   // R3 acceptance rule
            q.push_back(wseq);
            wseq++;
        end
    endtask

    task automatic rd_cycle(bit en);
        @(negedge rclk);
        if (rd_pend) check("R1/R9 read word", 32'(rdata), 32'(rd_exp));
        if (!empty) check("R8 empty low means data", 32'(q.size() > 0), 1);
        rd_en = en;
        if (en && !empty) rd_exp = q.pop_front();  // R3 acceptance rule
        else              rd_exp = '0;
        rd_pend = 1'b1;
    endtask

    task automatic settle(string tag);
        fork
            repeat (6) wr_cycle(1'b0);
            repeat (40) rd_cycle(1'b0);
        join
        @(negedge wclk);
        check({tag, " R5 full"},        32'(full),        32'(q.size() == DEPTH));
        check({tag, " R5 half_full"},   32'(half_full),   32'(q.size() >= DEPTH / 2));
        check({tag, " R5 almost_full"}, 32'(almost_full), 32'(q.size() >= AF));
        @(negedge rclk);
        check({tag, " R6 empty"},        32'(empty),        32'(q.size() == 0));
        check({tag, " R6 almost_empty"}, 32'(almost_empty), 32'(q.size() <= AE));
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        report();
        $finish;
    end

    initial begin
        #333;
        // R2: state while reset is held
        check("R2 rdata", 32'(rdata), 0);
        check("R2 empty", 32'(empty), 1);
        check("R2 almost_empty", 32'(almost_empty), 1);
        check("R2 full", 32'(full), 0);
        check("R2 almost_full", 32'(almost_full), 0);
        check("R2 half_full", 32'(half_full), 0);
        rst_n = 1'b1;

        // Fill with no reads, checking each threshold at its level
        repeat (3) wr_cycle(1'b1);
        settle("level3");
        repeat (5) wr_cycle(1'b1);
        settle("level8");
        repeat (6) wr_cycle(1'b1);
        settle("level14");
        repeat (2) wr_cycle(1'b1);
        // R3: four requests against a full FIFO must be refused
        repeat (4) wr_cycle(1'b1);
        settle("level16 R3");

        // Drain past empty: four refused reads give zero data
        repeat (20) rd_cycle(1'b1);
        settle("drained R3");

        // R4: bring read address to 10, then lead by one lap to write address 5
        repeat (10) wr_cycle(1'b1);
        settle("lap");
        repeat (10) rd_cycle(1'b1);
        settle("lap");
        repeat (11) wr_cycle(1'b1);
        settle("R4 wrapped 11");
        repeat (11) rd_cycle(1'b1);
        settle("R4 drained");

        // R1/R8: concurrent traffic, first writer-heavy, then reader-heavy
        fork
            repeat (400) wr_cycle($urandom_range(0, 3) != 0);
            repeat (2000) rd_cycle($urandom_range(0, 7) == 0);
        join
        fork
            repeat (400) wr_cycle($urandom_range(0, 3) == 0);
            repeat (2000) rd_cycle($urandom_range(0, 1) == 0);
        join
        settle("mixed");
        repeat (40) rd_cycle(1'b1);
        settle("final");
        rd_cycle(1'b0);
        check("R1 model drained", 32'(q.size()), 0);

        report();
        $finish;
    end

endmodule